// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the software-visible register set of a four-channel DMA controller, reached through a byte-wide I/O port. A 4-bit offset, a write strobe and a read strobe select one register at a time. Each channel holds a 16-bit transfer address and a 16-bit transfer count, and each is kept as a base copy and a current copy. The block also holds a mask bit per channel, mode bits for auto-initialise and address direction, and a terminal-count flag per channel.

All 16-bit values are reached one byte at a time. A single byte-pointer flip-flop selects the low or the high byte, and all channels share it. The transfer engine next to this block reads the per-channel mask, mode, base and current values from flat output buses. It returns terminal-count pulses, which set the flags, and request levels, which appear in the status byte.

Reads are combinational. `rdData` shows the addressed value while `rdEn` is high, and every side effect of the read takes place at the clock edge that ends the access. When `wrEn` and `rdEn` are both high in the same cycle, the write wins.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four channels are masked, all base and current addresses and counts are zero, every channel is set to increment without auto-initialise, no terminal-count flag is set, and the byte pointer selects the low byte.
- R2: A write at an even offset 0, 2, 4 or 6 loads the address of channel offset/2. A write at an odd offset 1, 3, 5 or 7 loads the count of channel (offset-1)/2. Each write loads the selected byte into both the base copy and the current copy.
- R3: Every read or write at offsets 0 to 7 toggles one byte pointer that all channels and both register kinds share. Low byte is 0 and high byte is 1. A read at offsets 0 to 7 returns the selected byte of the current value.
- R4: Either a read or a write at offset 0xC returns the byte pointer to the low byte.
- R5: A write at offset 0xA changes one mask bit. Data bits 1:0 select the channel, and data bit 2 is the new mask value (1 = masked).
- R6: A write at offset 0xB loads the mode of the channel in data bits 1:0. Bit 4 sets auto-initialise and bit 5 sets decrement. While `forceIncr` is high, the stored direction is increment whatever bit 5 holds.
- R7: A write at offset 0xD masks all channels, clears all terminal-count flags and returns the byte pointer to the low byte.
- R8: A write at offset 0xE unmasks all channels. A write at offset 0xF sets every mask from data bit n for channel n.
- R9: A read at offset 0x8 returns the terminal-count flags in bits 3:0 and the request levels in bits 7:4. All terminal-count flags are cleared at the end of the read.
- R10: A terminal-count pulse sets that channel's flag. A pulse in the same cycle as a status read still leaves the flag set after the read.
- R11: A read at offset 0x9 or at any offset from 0xA to 0xF returns 0xFF. Writes at offsets 0x8 and 0x9 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regOffset | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, valid while rdEn is high |
| forceIncr | input | 1 | Forces increment direction on mode writes |
| tcPulse | input | 4 | Terminal-count pulse per channel |
| reqLevel | input | 4 | Request level per channel |
| chanMask | output | 4 | Mask bit per channel |
| chanAutoInit | output | 4 | Auto-initialise bit per channel |
| chanDecr | output | 4 | Decrement bit per channel |
| baseAddr | output | 64 | Base addresses, channel n in bits 16n+15:16n |
| curAddr | output | 64 | Current addresses, same packing |
| baseCount | output | 64 | Base counts, same packing |
| curCount | output | 64 | Current counts, same packing |

## Verification
The assertions watch the mask bits and the read port on every cycle. Master clear, unmask-all and load-all must reach the masks one cycle after the write. The masks must hold when there is no write. Undefined reads must return all ones, the request half of the status byte must match the inputs, and a forced-increment mode write must never store decrement. The bench scenarios show what depends on history: the shared byte pointer across channels and register kinds, the clear-on-read of the flags, the set that wins over a clear in the same cycle, and writes that change nothing.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int NUM_CH   = 4;
  localparam int WORD_W   = 16;
  localparam int DATA_W   = 8;
  localparam int OFF_W    = 4;
  localparam int CH_SEL_W = $clog2(NUM_CH);

  typedef enum logic [1:0] {RD_NONE, RD_ADDR, RD_CNT, RD_STATUS} rdKind_t;

  typedef struct packed {
    logic [NUM_CH-1:0]   addrSel;
    logic [NUM_CH-1:0]   cntSel;
    logic                ptrToggle;
    logic                ptrClear;
    logic                maskSingle;
    logic                modeLoad;
    logic                masterClr;
    logic                unmaskAll;
    logic                maskLoadAll;
    logic                statusRead;
    rdKind_t             rdKind;
    logic [CH_SEL_W-1:0] rdChan;
  } regStrobe_t;
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_reg_pkg::*;
(
  input  logic [OFF_W-1:0] regOffset,
  input  logic             wrEn,
  input  logic             rdEn,
  output regStrobe_t       stb
);
  logic wrOp, rdOp, isWordReg;
  logic [CH_SEL_W-1:0] chanIdx;

  always_comb begin
    wrOp      = wrEn;
    rdOp      = rdEn & ~wrEn;
    isWordReg = ~regOffset[OFF_W-1];
    chanIdx   = regOffset[CH_SEL_W:1];

    stb             = '0;
    stb.rdKind      = RD_NONE;
    stb.rdChan      = chanIdx;
    stb.ptrToggle   = isWordReg & (wrOp | rdOp);
    stb.ptrClear    = (regOffset == 4'hC) & (wrOp | rdOp);
    stb.maskSingle  = wrOp & (regOffset == 4'hA);
    stb.modeLoad    = wrOp & (regOffset == 4'hB);
    stb.masterClr   = wrOp & (regOffset == 4'hD);
    stb.unmaskAll   = wrOp & (regOffset == 4'hE);
    stb.maskLoadAll = wrOp & (regOffset == 4'hF);
    stb.statusRead  = rdOp & (regOffset == 4'h8);

    if (wrOp && isWordReg) begin
      stb.addrSel[chanIdx] = ~regOffset[0];
      stb.cntSel[chanIdx]  = regOffset[0];
    end

    if (rdOp) begin
      if (isWordReg)                stb.rdKind = regOffset[0] ? RD_CNT : RD_ADDR;
      else if (regOffset == 4'h8)   stb.rdKind = RD_STATUS;
    end
  end
endmodule

// File: rtl/dma_reg_dp.sv
module dma_reg_dp
  import dma_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     forceIncr,
  input  logic [NUM_CH-1:0]        tcPulse,
  input  logic [NUM_CH-1:0]        reqLevel,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        chanMask,
  output logic [NUM_CH-1:0]        chanAutoInit,
  output logic [NUM_CH-1:0]        chanDecr,
  output logic [NUM_CH*WORD_W-1:0] baseAddr,
  output logic [NUM_CH*WORD_W-1:0] curAddr,
  output logic [NUM_CH*WORD_W-1:0] baseCount,
  output logic [NUM_CH*WORD_W-1:0] curCount
);
  logic              ptrHigh;
  logic [NUM_CH-1:0] tcFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ptrHigh <= 1'b0;
    else if (stb.masterClr || stb.ptrClear) ptrHigh <= 1'b0;
    else if (stb.ptrToggle)                 ptrHigh <= ~ptrHigh;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [WORD_W-1:0] bAddr, cAddr, bCnt, cCnt;
    logic hitData;
    assign hitData = (wrData[CH_SEL_W-1:0] == CH_SEL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bAddr <= '0; cAddr <= '0; bCnt <= '0; cCnt <= '0;
      end else begin
        if (stb.addrSel[c]) begin
          if (ptrHigh) begin
            bAddr[15:8] <= wrData; cAddr[15:8] <= wrData;
          end else begin
            bAddr[7:0] <= wrData;  cAddr[7:0] <= wrData;
          end
        end
        if (stb.cntSel[c]) begin
          if (ptrHigh) begin
            bCnt[15:8] <= wrData; cCnt[15:8] <= wrData;
          end else begin
            bCnt[7:0] <= wrData;  cCnt[7:0] <= wrData;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         chanMask[c] <= 1'b1;
      else if (stb.masterClr)            chanMask[c] <= 1'b1;
      else if (stb.unmaskAll)            chanMask[c] <= 1'b0;
      else if (stb.maskLoadAll)          chanMask[c] <= wrData[c];
      else if (stb.maskSingle && hitData) chanMask[c] <= wrData[2];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanAutoInit[c] <= 1'b0;
        chanDecr[c]     <= 1'b0;
      end else if (stb.modeLoad && hitData) begin
        chanAutoInit[c] <= wrData[4];
        chanDecr[c]     <= wrData[5] & ~forceIncr;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               tcFlag[c] <= 1'b0;
      else if (stb.masterClr)  tcFlag[c] <= 1'b0;
      else if (tcPulse[c])     tcFlag[c] <= 1'b1;
      else if (stb.statusRead) tcFlag[c] <= 1'b0;
    end

    assign baseAddr[c*WORD_W +: WORD_W]  = bAddr;
    assign curAddr[c*WORD_W +: WORD_W]   = cAddr;
    assign baseCount[c*WORD_W +: WORD_W] = bCnt;
    assign curCount[c*WORD_W +: WORD_W]  = cCnt;
  end

  logic [WORD_W-1:0] selWord;
  always_comb begin
    selWord = (stb.rdKind == RD_CNT) ? curCount[stb.rdChan*WORD_W +: WORD_W]
                                     : curAddr[stb.rdChan*WORD_W +: WORD_W];
    case (stb.rdKind)
      RD_ADDR, RD_CNT: rdData = ptrHigh ? selWord[15:8] : selWord[7:0];
      RD_STATUS:       rdData = {reqLevel, tcFlag};
      default:         rdData = '1;
    endcase
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [OFF_W-1:0]         regOffset,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     forceIncr,
  input  logic [NUM_CH-1:0]        tcPulse,
  input  logic [NUM_CH-1:0]        reqLevel,
  output logic [NUM_CH-1:0]        chanMask,
  output logic [NUM_CH-1:0]        chanAutoInit,
  output logic [NUM_CH-1:0]        chanDecr,
  output logic [NUM_CH*WORD_W-1:0] baseAddr,
  output logic [NUM_CH*WORD_W-1:0] curAddr,
  output logic [NUM_CH*WORD_W-1:0] baseCount,
  output logic [NUM_CH*WORD_W-1:0] curCount
);
  regStrobe_t stb;

  dma_reg_ctrl u_ctrl (
    .regOffset(regOffset), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  dma_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .forceIncr(forceIncr), .tcPulse(tcPulse), .reqLevel(reqLevel),
    .rdData(rdData), .chanMask(chanMask), .chanAutoInit(chanAutoInit),
    .chanDecr(chanDecr), .baseAddr(baseAddr), .curAddr(curAddr),
    .baseCount(baseCount), .curCount(curCount)
  );
endmodule

// File: rtl/dma_reg_chk.sv
module dma_reg_chk
  import dma_reg_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [OFF_W-1:0]         regOffset,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [DATA_W-1:0]        wrData,
  input logic [DATA_W-1:0]        rdData,
  input logic                     forceIncr,
  input logic [NUM_CH-1:0]        reqLevel,
  input logic [NUM_CH-1:0]        chanMask,
  input logic [NUM_CH-1:0]        chanDecr
);
  logic rdOnly;
  assign rdOnly = rdEn & ~wrEn;

  p_master_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == 4'hD) |=> chanMask == '1);

  p_unmask_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == 4'hE) |=> chanMask == '0);

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == 4'hF) |=> chanMask == $past(wrData[NUM_CH-1:0]));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(chanMask));

  p_undef_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && regOffset >= 4'h9) |-> rdData == 8'hFF);

  p_status_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && regOffset == 4'h8) |-> rdData[7:4] == reqLevel);

  p_force_incr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == 4'hB && forceIncr) |=>
      (chanDecr & (NUM_CH'(1) << $past(wrData[CH_SEL_W-1:0]))) == '0);
endmodule

bind dma_regfile dma_reg_chk i_chk (.*);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  import dma_reg_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regOffset = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic forceIncr = 1'b0;
  logic [3:0] tcPulse = '0, reqLevel = '0;
  logic [3:0] chanMask, chanAutoInit, chanDecr;
  logic [63:0] baseAddr, curAddr, baseCount, curCount;
  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  dma_regfile i_dma_regfile (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] off, logic [7:0] d);
    @(negedge clk); regOffset = off; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(logic [3:0] off, output logic [7:0] d);
    @(negedge clk); regOffset = off; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  function automatic logic [15:0] w(logic [63:0] v, int ch);
    return v[ch*16 +: 16];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mask", chanMask, 4'hF);
    chk("R1 autoinit", chanAutoInit, 0);
    chk("R1 decr", chanDecr, 0);
    chk("R1 values", {|baseAddr, |curAddr, |baseCount, |curCount}, 0);
    busRead(4'h8, d);
    chk("R1 status", d, 8'h00);
    busWrite(4'h0, 8'h5A);
    chk("R1 pointer low", w(baseAddr, 0), 16'h005A);
    busWrite(4'h0, 8'h00);
  endtask

  task automatic t_addr_count;
    logic [7:0] d;
    busWrite(4'hC, 0);
    busWrite(4'h2, 8'h34); busWrite(4'h2, 8'h12);
    chk("R2 base addr ch1", w(baseAddr, 1), 16'h1234);
    chk("R2 cur addr ch1", w(curAddr, 1), 16'h1234);
    busWrite(4'h7, 8'hCD); busWrite(4'h7, 8'hAB);
    chk("R2 base cnt ch3", w(baseCount, 3), 16'hABCD);
    chk("R2 cur cnt ch3", w(curCount, 3), 16'hABCD);
    chk("R2 ch0 addr untouched", w(baseAddr, 0), 16'h005A);
    busRead(4'h2, d); chk("R3 read low", d, 8'h34);
    busRead(4'h2, d); chk("R3 read high", d, 8'h12);
  endtask

  task automatic t_shared_ptr;
    logic [7:0] d;
    busWrite(4'hC, 0);
    busWrite(4'h0, 8'h55);
    busWrite(4'h5, 8'h66);
    chk("R3 shared pointer", w(curCount, 2), 16'h6600);
    busRead(4'h1, d);
    busWrite(4'h4, 8'h77);
    chk("R3 read toggles", w(baseAddr, 2), 16'h7700);
  endtask

  task automatic t_ptr_clear;
    logic [7:0] d;
    busWrite(4'hC, 0);
    busWrite(4'h6, 8'h11);
    busRead(4'hC, d);
    chk("R11 read 0xC", d, 8'hFF);
    busWrite(4'h6, 8'h22);
    chk("R4 read clears", w(baseAddr, 3), 16'h0022);
    busWrite(4'hC, 0);
    busWrite(4'h6, 8'h33);
    chk("R4 write clears", w(baseAddr, 3), 16'h0033);
    busWrite(4'hC, 0);
  endtask

  task automatic t_mask;
    busWrite(4'hE, 0);
    busWrite(4'hA, 8'h06);
    chk("R5 set ch2", chanMask, 4'b0100);
    busWrite(4'hA, 8'h07);
    chk("R5 set ch3", chanMask, 4'b1100);
    busWrite(4'hA, 8'h02);
    chk("R5 clear ch2", chanMask, 4'b1000);
  endtask

  task automatic t_mode;
    busWrite(4'hB, 8'h31);
    chk("R6 autoinit ch1", chanAutoInit, 4'b0010);
    chk("R6 decr ch1", chanDecr, 4'b0010);
    forceIncr = 1'b1;
    busWrite(4'hB, 8'h22);
    forceIncr = 1'b0;
    chk("R6 forced incr ch2", chanDecr, 4'b0010);
    busWrite(4'hB, 8'h01);
    chk("R6 reload ch1", {chanAutoInit, chanDecr}, 8'h00);
  endtask

  task automatic t_multi_mask;
    busWrite(4'hF, 8'hFA);
    chk("R8 load all", chanMask, 4'b1010);
    busWrite(4'hE, 0);
    chk("R8 unmask all", chanMask, 4'b0000);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); tcPulse = 4'b1001; reqLevel = 4'b0110;
    @(negedge clk); tcPulse = 0;
    busRead(4'h8, d); chk("R9 status", d, 8'h69);
    busRead(4'h8, d); chk("R9 flags cleared", d, 8'h60);
    reqLevel = 0;
    @(negedge clk); regOffset = 4'h8; rdEn = 1'b1; tcPulse = 4'b0010;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0; tcPulse = 0;
    chk("R10 read before set", d, 8'h00);
    busRead(4'h8, d); chk("R10 set wins", d, 8'h02);
  endtask

  task automatic t_master;
    logic [7:0] d;
    @(negedge clk); tcPulse = 4'b0100;
    @(negedge clk); tcPulse = 0;
    busWrite(4'hE, 0);
    busWrite(4'h0, 8'hAA);
    busWrite(4'hD, 0);
    chk("R7 masks", chanMask, 4'hF);
    busRead(4'h8, d); chk("R7 flags", d, 8'h00);
    busWrite(4'h0, 8'hBB);
    chk("R7 pointer", w(baseAddr, 0)[7:0], 8'hBB);
    busWrite(4'h0, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    logic [63:0] sAddr, sCnt;
    logic [11:0] sMode;
    @(negedge clk); tcPulse = 4'b0001;
    @(negedge clk); tcPulse = 0;
    sAddr = baseAddr; sCnt = curCount;
    sMode = {chanMask, chanAutoInit, chanDecr};
    busWrite(4'h8, 8'hFF);
    busWrite(4'h9, 8'hFF);
    chk("R11 state kept", {sMode, 20'h0}, {chanMask, chanAutoInit, chanDecr, 20'h0});
    chk("R11 words kept", {31'h0, (sAddr == baseAddr) && (sCnt == curCount)}, 1);
    busRead(4'h8, d); chk("R11 flags kept", d, 8'h01);
    busWrite(4'h0, 8'h44);
    chk("R11 pointer kept", w(baseAddr, 0), 16'h0044);
    busWrite(4'hC, 0);
    busRead(4'h9, d); chk("R11 read 0x9", d, 8'hFF);
    busRead(4'hA, d); chk("R11 read 0xA", d, 8'hFF);
    busRead(4'hF, d); chk("R11 read 0xF", d, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_count();
    t_shared_ptr();
    t_ptr_clear();
    t_mask();
    t_mode();
    t_multi_mask();
    t_status();
    t_master();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule